// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Word-Boundary Slip

This block turns a one-bit serial stream into parallel words in single-data-rate mode. A fast bit clock samples the serial input on every rising edge. A word clock running at one eighth of that rate, with its rising edges placed midway between two bit-clock rising edges, presents one assembled word per cycle to the surrounding logic. The bit that arrives first in each word lands in the most significant output position.

A slip input lets downstream alignment logic move the word boundary. Each accepted request drops one bit from the stream, so the boundary moves one position later. With a repeating training pattern on the line, the output steps through the cyclic rotations of that pattern until it matches the expected word. A request is one word-clock cycle with the slip input high. The input must be low for at least one word-clock cycle between two requests, and a request that breaks this spacing is ignored. A build-time parameter can disable the slip function entirely.

Top module: `bitslip_deser`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the parallel output reads zero on the next word-clock edge, and any slip state already accepted is discarded.
- R2: Each word-clock cycle delivers WORD_W (default 8) consecutive serial bits, with the earliest received bit in bit WORD_W-1 of the output and the latest in bit 0.
- R3: With slip enabled, a word-clock edge that samples the slip input high, after an edge that sampled it low, is accepted as one request.
- R4: The output on the word-clock edge that captures a request still has the old alignment. The new alignment appears from the following word-clock edge, so logic clocked by the word clock first samples it two edges after the capture.
- R5: Each accepted request moves the boundary one bit later. With a repeating WORD_W-bit pattern P on the line, k requests give P rotated left by k (MSB-first).
- R6: After WORD_W accepted requests the alignment is back to where it started.
- R7: A word-clock edge that samples the slip input high, directly after an edge that also sampled it high, is not a request and leaves the alignment unchanged.
- R8: With SLIP_EN set to 0, the slip input has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Fast bit clock; serial data sampled on its rising edge |
| wordClk | input | 1 | Word clock, one eighth of the bit rate, rising edges midway between bit-clock rising edges |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| serIn | input | 1 | Serial data input |
| slipIn | input | 1 | Word-boundary slip request (word-clock domain) |
| qOut | output | WORD_W | Parallel word; earliest bit in the MSB |

## Verification
The bench builds two instances at WORD_W = 8 and feeds both the same serial stream: one with SLIP_EN = 1 and one with SLIP_EN = 0. Every slip request therefore also acts as a stimulus to prove the disabled instance unchanged. On the enabled instance the bench walks the repeating pattern 1001_0011 through all eight rotations and back. It also checks the two-edge latency and the handling of a request held high for two edges. A later phase switches to a non-repeating stream, where the boundary can only be checked bit for bit against the model.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadWord;   // bit domain: last bit of a word is on serIn this cycle
    logic slipStep;   // word domain: advance the boundary by one bit
  } slipStrb_t;

endpackage

// File: rtl/bitslip_ctrl.sv
module bitslip_ctrl
  import bitslip_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter bit SLIP_EN = 1'b1
) (
  input  logic      bitClk,
  input  logic      wordClk,
  input  logic      rst,
  input  logic      slipIn,
  output slipStrb_t strb
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             slipSeen;

  // Bit position inside the word being assembled
  always_ff @(posedge bitClk) begin
    if (rst)                   bitCnt <= '0;
    else if (bitCnt == LAST_BIT) bitCnt <= '0;
    else                       bitCnt <= bitCnt + 1'b1;
  end

  // Slip input level at the previous word edge, for the spacing rule
  always_ff @(posedge wordClk) begin
    if (rst) slipSeen <= 1'b0;
    else     slipSeen <= slipIn;
  end

  assign strb.loadWord = (bitCnt == LAST_BIT);

  generate
    if (SLIP_EN) begin : g_slip
      assign strb.slipStep = slipIn & ~slipSeen;
    end else begin : g_noSlip
      assign strb.slipStep = 1'b0;
    end
  endgenerate

  // R2: a word completes once per word period, never on two adjacent bit cycles
  assert_load_period_R2: assert property (@(posedge bitClk) disable iff (rst)
    strb.loadWord |=> !strb.loadWord)
    else $error("load strobe on consecutive bit cycles");

endmodule

// File: rtl/bitslip_datapath.sv
module bitslip_datapath
  import bitslip_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic                        bitClk,
  input  logic                        wordClk,
  input  logic                        rst,
  input  logic                        serIn,
  input  slipStrb_t                   strb,
  output logic [WORD_W-1:0]           qOut,
  output logic [$clog2(WORD_W)-1:0]   slipPos
);

  localparam int SEL_W = $clog2(WORD_W);
  localparam int WIN_W = 2 * WORD_W;
  localparam logic [SEL_W-1:0] LAST_POS = SEL_W'(WORD_W - 1);

  // Bit-clock domain: shift and word assembly
  logic [WORD_W-2:0] shiftReg;
  logic [WORD_W-1:0] wordReg;

  always_ff @(posedge bitClk) begin
    if (rst) begin
      shiftReg <= '0;
      wordReg  <= '0;
    end else begin
      shiftReg <= {shiftReg[WORD_W-3:0], serIn};
      if (strb.loadWord) wordReg <= {shiftReg, serIn};
    end
  end

  // Word-clock domain: two-word window and boundary select
  logic [WORD_W-1:0] capWord;
  logic [WORD_W-1:0] prevWord;
  logic [SEL_W-1:0]  offset;
  logic [WIN_W-1:0]  window;
  logic [WORD_W-1:0] selWord;

  assign window  = {prevWord, capWord};
  assign selWord = window[(WIN_W - 1) - int'(offset) -: WORD_W];

  always_ff @(posedge wordClk) begin
    if (rst) begin
      capWord  <= '0;
      prevWord <= '0;
      offset   <= '0;
      qOut     <= '0;
    end else begin
      capWord  <= wordReg;
      prevWord <= capWord;
      qOut     <= selWord;
      if (strb.slipStep) begin
        if (offset == LAST_POS) offset <= '0;
        else                    offset <= offset + 1'b1;
      end
    end
  end

  assign slipPos = offset;

  // R1: a word edge that samples reset leaves the output at zero
  assert_reset_clear_R1: assert property (@(posedge wordClk)
    $past(rst) |-> (qOut == '0))
    else $error("output not cleared by reset");

  // R6: a step from the last position wraps to the original alignment
  assert_wrap_R6: assert property (@(posedge wordClk) disable iff (rst)
    (strb.slipStep && offset == LAST_POS) |=> (offset == '0))
    else $error("boundary did not wrap");

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import bitslip_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter bit SLIP_EN = 1'b1
) (
  input  logic              bitClk,
  input  logic              wordClk,
  input  logic              rst,
  input  logic              serIn,
  input  logic              slipIn,
  output logic [WORD_W-1:0] qOut
);

  localparam int SEL_W = $clog2(WORD_W);

  slipStrb_t        strb;
  logic [SEL_W-1:0] slipPos;

  bitslip_ctrl #(.WORD_W(WORD_W), .SLIP_EN(SLIP_EN)) u_ctrl (
    .bitClk (bitClk),
    .wordClk(wordClk),
    .rst    (rst),
    .slipIn (slipIn),
    .strb   (strb)
  );

  bitslip_datapath #(.WORD_W(WORD_W)) u_dp (
    .bitClk (bitClk),
    .wordClk(wordClk),
    .rst    (rst),
    .serIn  (serIn),
    .strb   (strb),
    .qOut   (qOut),
    .slipPos(slipPos)
  );

  // R7: a second high edge in a row must not move the boundary
  assert_spacing_R7: assert property (@(posedge wordClk) disable iff (rst)
    (slipIn && $past(slipIn) && !$past(rst)) |=> $stable(slipPos))
    else $error("back-to-back slip was taken");

  generate
    if (SLIP_EN) begin : g_chk
      // R3: a high edge after a low edge moves the boundary
      assert_accept_R3: assert property (@(posedge wordClk) disable iff (rst)
        (slipIn && !$past(slipIn)) |=> (slipPos != $past(slipPos)))
        else $error("valid slip request not taken");
    end
  endgenerate

endmodule

// File: tb/bitslip_deser_bench.sv
module bitslip_deser_bench;

  localparam logic [7:0] PAT = 8'b1001_0011;

  logic bitClk = 1'b0;
  logic wordClk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b0;
  logic slipIn = 1'b0;
  logic [7:0] qEn, qDis;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int patMode = 0;
  int ptr = 0;
  bit hist[$];

  // 125 MHz bit clock; word clock rises midway between bit rising edges
  always #4 bitClk = ~bitClk;
  initial begin
    #8;
    forever begin wordClk = 1'b1; #32; wordClk = 1'b0; #32; end
  end

  bitslip_deser #(.WORD_W(8), .SLIP_EN(1'b1)) u_bitslip_deser (
    .bitClk(bitClk), .wordClk(wordClk), .rst(rst), .serIn(serIn),
    .slipIn(slipIn), .qOut(qEn));

  bitslip_deser #(.WORD_W(8), .SLIP_EN(1'b0)) u_bitslip_deser_noSlip (
    .bitClk(bitClk), .wordClk(wordClk), .rst(rst), .serIn(serIn),
    .slipIn(slipIn), .qOut(qDis));

  function automatic bit patBit(int idx);
    if (patMode == 0) return PAT[7 - (idx % 8)];
    return bit'(((idx * 73) ^ (idx >> 2) ^ (idx >> 5)) & 1);
  endfunction

  function automatic bit histBit(int i);
    if (i < 0 || i >= int'(hist.size())) return 1'b0;
    return hist[i];
  endfunction

  function automatic logic [7:0] winAt(int wIdx, int s);
    logic [7:0] w;
    for (int k = 0; k < 8; k++) w[7-k] = histBit(8 * wIdx + s + k);
    return w;
  endfunction

  function automatic logic [7:0] rotl(logic [7:0] x, int s);
    int r = s % 8;
    if (r == 0) return x;
    return (x << r) | (x >> (8 - r));
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Serial source and record of bits the design captures
  always @(posedge bitClk) begin
    if (rst) begin hist.delete(); ptr = 0; end
    else begin hist.push_back(serIn); ptr++; end
    #2 serIn = patBit(ptr);
  end

  // Behavioural reference, compared after every word edge
  int cA = -1, cB = -1, sEn = 0;
  bit slipLast = 1'b0;
  always @(posedge wordClk) begin
    logic [7:0] eEn, eDis;
    if (rst) begin
      cA = -1; cB = -1; sEn = 0; slipLast = 1'b0;
      eEn = '0; eDis = '0;
    end else begin
      eEn  = winAt(cB, sEn);
      eDis = winAt(cB, 0);
      if (slipIn && !slipLast) sEn = (sEn + 1) % 8;
      slipLast = slipIn;
      cB = cA;
      cA = int'(hist.size()) / 8 - 1;
    end
    #16;
    if (!done) begin
      chk("R2 model enabled", qEn, eEn);
      chk("R8 model disabled", qDis, eDis);
    end
  end

  task automatic issueSlip(int rotBefore, bit checkLat);
    @(posedge wordClk); #24 slipIn = 1'b1;
    @(posedge wordClk); #16;
    if (checkLat) chk("R4 old alignment at capture edge", qEn, rotl(PAT, rotBefore));
    #8 slipIn = 1'b0;
    @(posedge wordClk); #16;
    if (checkLat) chk("R4 new alignment one edge later", qEn, rotl(PAT, rotBefore + 1));
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge wordClk);
    #16;
    chk("R1 reset output enabled", qEn, 8'h00);
    chk("R1 reset output disabled", qDis, 8'h00);
    #6 rst = 1'b0;

    repeat (4) @(posedge wordClk);
    #16;
    chk("R2 first word msb first", qEn, PAT);
    chk("R2 first word disabled", qDis, PAT);

    // R3 / R4: first request with latency checks
    issueSlip(0, 1'b1);
    chk("R3 single request rotates by one", qEn, rotl(PAT, 1));

    // R5 / R8: walk the remaining rotations
    for (int i = 2; i <= 8; i++) begin
      issueSlip(i - 1, 1'b1);
      if (i < 8) chk("R5 rotation step", qEn, rotl(PAT, i));
      else       chk("R6 eight slips restore alignment", qEn, PAT);
      chk("R8 disabled instance unaffected", qDis, PAT);
    end

    // R7: request held high across two edges counts once
    @(posedge wordClk); #24 slipIn = 1'b1;
    @(posedge wordClk); #24;
    @(posedge wordClk); #24 slipIn = 1'b0;
    @(posedge wordClk); #16;
    chk("R7 held request advances once", qEn, rotl(PAT, 1));
    chk("R8 disabled after held request", qDis, PAT);

    // R1: reset mid-run discards the accepted slip
    #6 rst = 1'b1;
    repeat (2) @(posedge wordClk);
    #16 chk("R1 output cleared mid-run", qEn, 8'h00);
    #6 rst = 1'b0;
    repeat (4) @(posedge wordClk);
    #16 chk("R1 alignment restored after reset", qEn, PAT);

    // Non-repeating stream with slips, checked by the model
    patMode = 1;
    for (int i = 0; i < 5; i++) issueSlip(0, 1'b0);
    repeat (20) @(posedge wordClk);
    #20;
    finishRun();
  end

endmodule